// File: doc/BRIEF.md
# Up-Counting Compare Timer

This block is a word-wide timer that counts up by one on every system clock while it runs. Software loads a start count and a match limit, then sets the enable bit. When the running count equals the limit, the block raises a one-cycle interrupt pulse and returns the count to zero. It then either keeps counting, with the restart bit set, or clears its own enable bit and halts.

Software reaches the three registers through a single-cycle register port. A write takes effect at the clock edge on which the write strobe is high. Reads are combinational from the selected address. The interrupt output comes straight from a flop, so it can feed an interrupt controller with no logic in between.

Top module: `cmp_timer`

## Requirements
- R1: Word address 0 is control: bit 0 enables counting, bit 1 selects restart on match, and the other bits read as zero. Address 1 is the match limit and address 2 is the live count. Address 3 reads zero, and writes to it change nothing.
- R2: While reset is asserted and right after it, all three registers read zero and irq_o is low.
- R3: While enabled, the count grows by exactly one per clock, and a read of address 2 returns the current count.
- R4: A match occurs on a clock edge at which the timer is enabled and the count equals the match limit. irq_o is high for the one cycle that follows that edge, and the count becomes zero at that edge.
- R5: On a match with the restart bit clear, hardware clears the enable bit, so control reads back zero and counting stops.
- R6: On a match with the restart bit set, the timer keeps running and pulses again after every further limit+1 clocks.
- R7: Writing control with enable clear freezes the count. Writing it with enable set resumes counting from the value held at address 2.
- R8: A write to the match limit is used for comparison from the next edge on, even while the timer is running.
- R9: A count write while running replaces the live count and overrides the increment on that edge.
- R10: A control write on the same edge as a one-shot match wins over the hardware clearing of the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | One-cycle match pulse |

## Verification
Each register write lands on the edge it is driven into. A read is valid in the same cycle. A match that starts from count S with limit C, enabled on edge W, falls on edge W+C-S+1, and irq_o is high in the cycle after that edge. For every scenario the driver works out that edge number from the requirements and queues it. A monitor counts edges, samples irq_o at the falling clock, and matches every pulse against the head of the queue, so both an early pulse and a missing pulse are reported. Count reads are taken at known edge offsets from the enable write, so the expected value follows from the edge number alone.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_LIMIT = 2'd1,
    A_COUNT = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic restart;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             hit_i,
  output logic             run_o,
  output logic [CNT_W-1:0] limit_o,
  output logic             count_we_o,
  output logic [CNT_W-1:0] rdata_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] limit_q;
  logic             ctrl_we, limit_we;

  assign ctrl_we    = we_i && (addr_i == A_CTRL);
  assign limit_we   = we_i && (addr_i == A_LIMIT);
  assign count_we_o = we_i && (addr_i == A_COUNT);

  // software write beats the hardware clear on a one-shot match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    else if (hit_i && !ctrl_q.restart) ctrl_q.enable <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) limit_q <= '0;
    else if (limit_we) limit_q <= wdata_i;
  end

  assign run_o   = ctrl_q.enable;
  assign limit_o = limit_q;

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      A_LIMIT: rdata_o = limit_q;
      A_COUNT: rdata_o = count_i;
      default: rdata_o = '0;
    endcase
  end

  p_oneshot_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !ctrl_q.restart && !ctrl_we) |=> !run_o);
  p_sw_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we |=> (run_o == $past(wdata_i[0])));
  p_restart_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && ctrl_q.restart && !ctrl_we) |=> run_o);
endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             count_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic             hit_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] count_q;
  logic             irq_q;

  assign hit_o = run_i && (count_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else if (count_we_i) count_q <= wdata_i;
    else if (hit_o) count_q <= '0;
    else if (run_i) count_q <= count_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else irq_q <= hit_o;
  end

  assign count_o = count_q;
  assign irq_o   = irq_q;

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !hit_o && !count_we_i) |=> (count_o == $past(count_o) + CNT_W'(1)));
  p_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !count_we_i) |=> $stable(count_o));
  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !count_we_i) |=> (count_o == '0));
  p_irq_on_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> irq_o);
  p_irq_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |=> !irq_o);
  p_overwrite_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_we_i |=> (count_o == $past(wdata_i)));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic             run, hit, count_we;
  logic [CNT_W-1:0] limit, count;

  cmp_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .count_i    (count),
    .hit_i      (hit),
    .run_o      (run),
    .limit_o    (limit),
    .count_we_o (count_we),
    .rdata_o    (reg_rdata_o)
  );

  cmp_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .limit_i    (limit),
    .count_we_i (count_we),
    .wdata_i    (reg_wdata_i),
    .count_o    (count),
    .hit_o      (hit),
    .irq_o      (irq_o)
  );

  p_reset_quiet_r2: assert property (@(posedge clk_i) !rst_ni |=> !irq_o);
endmodule

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int exp_q[$];
  string tag_q[$];

  cmp_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic void check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  // monitor: every pulse must match the head of the expectation queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) begin
        if (exp_q.size() == 0) check(0, "R4 unexpected irq", cyc, -1);
        else begin
          check(exp_q[0] == cyc, tag_q[0], cyc, exp_q[0]);
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end else if (exp_q.size() != 0 && exp_q[0] <= cyc) begin
        check(0, {tag_q[0], " missing irq"}, cyc, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic expect_irq(int edge_no, string tag);
    exp_q.push_back(edge_no);
    tag_q.push_back(tag);
  endtask

  // called at a falling edge; returns the edge number the write lands on
  task automatic wr(input logic [1:0] a, input logic [31:0] d, output int w);
    we = 1'b1; addr = a; wdata = d;
    w = cyc + 1;
    @(posedge clk);
    #1 we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    addr = a;
    #1 check(rdata == e, tag, rdata, e);
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    #(CLK_P*20000);
    check(0, "watchdog", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int w, w2, wc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(irq == 1'b0, "R2 irq in reset", irq, 0);
    rst_n = 1'b1;
    rd(2'd0, 0, "R2 ctrl after reset");
    rd(2'd1, 0, "R2 limit after reset");
    rd(2'd2, 0, "R2 count after reset");

    // R1: upper control bits and unmapped address
    wr(2'd0, 32'hFFFF_FFFC, w);
    rd(2'd0, 0, "R1 ctrl upper bits");
    wr(2'd1, 32'd77, w);
    wr(2'd3, 32'hFFFF_FFFF, w);
    rd(2'd3, 0, "R1 addr3 reads zero");
    rd(2'd1, 77, "R1 limit untouched by addr3");

    // R4/R5 one-shot: start 2, limit 5
    wr(2'd1, 32'd5, w);
    wr(2'd2, 32'd2, w);
    wr(2'd0, 32'd1, w);
    expect_irq(w + 4, "R4 one-shot match edge");
    wait_until(w + 8);
    rd(2'd0, 0, "R5 enable cleared");
    rd(2'd2, 0, "R4 count back to zero");

    // R3/R7 run, read live, freeze, resume
    wr(2'd1, 32'd100, w);
    wr(2'd0, 32'd1, w);
    wait_until(w + 6);
    rd(2'd2, 6, "R3 live count");
    wr(2'd0, 32'd0, w2);
    rd(2'd2, w2 - w, "R7 frozen value");
    @(negedge clk); @(negedge clk);
    rd(2'd2, w2 - w, "R7 still frozen");
    wr(2'd2, 32'd95, w);
    wr(2'd0, 32'd1, w);
    expect_irq(w + 6, "R7 resume from loaded count");
    wait_until(w + 8);

    // R6 autorestart: limit 3, start 0
    wr(2'd1, 32'd3, w);
    wr(2'd2, 32'd0, w);
    wr(2'd0, 32'd3, w);
    expect_irq(w + 4, "R6 first pulse");
    expect_irq(w + 8, "R6 second pulse");
    expect_irq(w + 12, "R6 third pulse");
    wait_until(w + 13);
    rd(2'd0, 3, "R6 still enabled");
    wr(2'd0, 32'd0, w2);
    rd(2'd2, 2, "R6 count after stop");
    wait_until(w + 20);

    // R8 limit change while running
    wr(2'd2, 32'd0, w);
    wr(2'd1, 32'd50, w);
    wr(2'd0, 32'd1, w);
    wait_until(w + 4);
    wr(2'd1, 32'd8, w2);
    expect_irq(w + 9, "R8 new limit used");
    wait_until(w + 12);
    rd(2'd0, 0, "R8 stopped after match");

    // R9 live count overwrite
    wr(2'd1, 32'd20, w);
    wr(2'd0, 32'd1, w);
    wait_until(w + 2);
    wr(2'd2, 32'd15, wc);
    wait_until(wc + 2);
    rd(2'd2, 17, "R9 count after overwrite");
    expect_irq(wc + 6, "R9 match from overwritten count");
    wait_until(wc + 8);

    // R10 software control write on the match edge
    wr(2'd1, 32'd4, w);
    wr(2'd0, 32'd1, w);
    expect_irq(w + 5, "R10 first match");
    wait_until(w + 4);
    wr(2'd0, 32'd1, w2);
    rd(2'd0, 1, "R10 software write kept enable");
    expect_irq(w + 10, "R10 second match");
    wait_until(w + 12);
    rd(2'd0, 0, "R10 cleared after second match");

    check(exp_q.size() == 0, "R4 pending pulses", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule